// File: doc/BRIEF.md
# Wait-for-interrupt standby controller

This block moves a processor core between a normal running state and a low-power standby state. The core asks for standby by pulsing a wait-for-interrupt request. The controller does not stop the clocks straight away. It first waits until every outstanding memory access and every queued DMA job has finished. It then removes the core clock enable, and one cycle later it raises a standby flag that the rest of the system can watch. If the DMA engine reports an external error while this entry sequence is running, the sequence is abandoned and the core keeps running.

An interrupt on any line brings the core back, whether or not that line is masked further down the chain. A debug request also brings the core back, but only while debug is enabled. The wake sources are asynchronous, so they pass through a synchronizer on the always-on clock before the controller acts on them. The debug clock enable is never removed, so the debug channel stays usable in every state. Reset always returns the block to the running state.

The clock-gate cells, the DMA engine and the interrupt controller are not part of this block. They appear only as the enable outputs and the status inputs.

Top module: `wfi_standby_ctrl`

## Requirements
- R1: During and after reset, with no request pending, `core_clk_en_o` is 1, `standby_o` is 0 and `dbg_clk_en_o` is 1.
- R2: The block leaves the running state only when `wfi_req_i` is sampled high while running. With `wfi_req_i` low, `core_clk_en_o` stays 1 and `standby_o` stays 0.
- R3: After a request is accepted, the block waits in a drain step for as long as `mem_busy_i` is high. During the wait, `core_clk_en_o` stays 1.
- R4: The drain step also waits for as long as `dma_busy_i` is high. DMA keeps its clock during the wait.
- R5: If `dma_err_i` is high during the drain step or the gating step, the next cycle is the running state. `core_clk_en_o` is then 1 and `standby_o` never rises.
- R6: With both busy inputs low, `core_clk_en_o` falls one edge after the drain step is entered. `standby_o` rises one edge after that, so the standby flag is never high while the core clock is enabled.
- R7: In standby, a high level on any bit of `irq_i` wakes the core. The level is seen after two synchronizer edges. On the third edge `core_clk_en_o` rises and `standby_o` falls in the same cycle.
- R8: While `dbg_en_i` is 1, `dbg_req_i` wakes the core with the same timing as R7. While `dbg_en_i` is 0, `dbg_req_i` has no effect and standby is kept.
- R9: `dbg_clk_en_o` is 1 in every state, including standby.
- R10: Asserting `rst_n` low in any state, including standby, returns the block to the running state at once: `core_clk_en_o` goes to 1 and `standby_o` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wfi_req_i | input | 1 | Wait-for-interrupt request from the core |
| mem_busy_i | input | 1 | Explicit memory accesses are still outstanding |
| dma_busy_i | input | 1 | DMA has queued or active work |
| dma_err_i | input | 1 | DMA external-error interrupt |
| irq_i | input | NUM_IRQ | Interrupt request lines, taken before any masking |
| dbg_req_i | input | 1 | External debug request |
| dbg_en_i | input | 1 | Debug enable |
| core_clk_en_o | output | 1 | Enable for the gated core clocks |
| dbg_clk_en_o | output | 1 | Enable for the debug clock, always 1 |
| standby_o | output | 1 | The core is in standby |

## Verification
The assertions assume that the busy flags, the DMA error and the debug enable are synchronous to the clock. They also assume that a wake source stays high until the core has left standby, so a level that arrives during the single gating cycle is still present once standby is reached. The directed tasks change every input just after a falling edge. Each task holds its interrupt or debug level until it has checked the return to the running state, and it releases that level before the next scenario begins.

// File: rtl/wfi_pkg.sv
package wfi_pkg;
  typedef enum logic [1:0] {
    PWR_RUN     = 2'b00,
    PWR_DRAIN   = 2'b01,
    PWR_GATE    = 2'b10,
    PWR_STANDBY = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/wfi_wake_sync.sv
module wfi_wake_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else begin
          if (s == 0) stage_q[s] <= async_i;
          else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/wfi_power_fsm.sv
module wfi_power_fsm
  import wfi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n,
  input  logic       wfi_req_i,
  input  logic       mem_busy_i,
  input  logic       dma_busy_i,
  input  logic       dma_err_i,
  input  logic       wake_i,
  output pwr_state_e state_o,
  output logic       core_clk_en_o,
  output logic       standby_o
);
  pwr_state_e state_q, state_d;
  logic       drained;

  assign drained = !mem_busy_i && !dma_busy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PWR_RUN:     if (wfi_req_i) state_d = PWR_DRAIN;
      PWR_DRAIN: begin
        if (dma_err_i)    state_d = PWR_RUN;
        else if (drained) state_d = PWR_GATE;
      end
      PWR_GATE:    state_d = dma_err_i ? PWR_RUN : PWR_STANDBY;
      PWR_STANDBY: if (wake_i) state_d = PWR_RUN;
      default:     state_d = PWR_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= PWR_RUN;
    else        state_q <= state_d;
  end

  // Clock stays on while running or draining; the flag follows one state later.
  assign core_clk_en_o = (state_q == PWR_RUN) || (state_q == PWR_DRAIN);
  assign standby_o     = (state_q == PWR_STANDBY);
  assign state_o       = state_q;
endmodule

// File: rtl/wfi_standby_ctrl.sv
module wfi_standby_ctrl
  import wfi_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_n,
  input  logic               wfi_req_i,
  input  logic               mem_busy_i,
  input  logic               dma_busy_i,
  input  logic               dma_err_i,
  input  logic [NUM_IRQ-1:0] irq_i,
  input  logic               dbg_req_i,
  input  logic               dbg_en_i,
  output logic               core_clk_en_o,
  output logic               dbg_clk_en_o,
  output logic               standby_o
);
  localparam int WAKE_SRCS = 2;
  localparam int SRC_IRQ   = 0;
  localparam int SRC_DBG   = 1;

  logic [WAKE_SRCS-1:0] wake_raw, wake_sync;
  logic                 wake;
  pwr_state_e           state_q;

  // Interrupts are taken before any mask, so one OR covers every line.
  assign wake_raw[SRC_IRQ] = |irq_i;
  assign wake_raw[SRC_DBG] = dbg_req_i;

  wfi_wake_sync #(
    .WIDTH  (WAKE_SRCS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .async_i (wake_raw),
    .sync_o  (wake_sync)
  );

  assign wake = wake_sync[SRC_IRQ] || (wake_sync[SRC_DBG] && dbg_en_i);

  wfi_power_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_n         (rst_n),
    .wfi_req_i     (wfi_req_i),
    .mem_busy_i    (mem_busy_i),
    .dma_busy_i    (dma_busy_i),
    .dma_err_i     (dma_err_i),
    .wake_i        (wake),
    .state_o       (state_q),
    .core_clk_en_o (core_clk_en_o),
    .standby_o     (standby_o)
  );

  assign dbg_clk_en_o = 1'b1;
endmodule

// File: rtl/wfi_standby_ctrl_chk.sv
module wfi_standby_ctrl_chk
  import wfi_pkg::*;
(
  input logic       clk_i,
  input logic       rst_n,
  input logic       wfi_req_i,
  input logic       mem_busy_i,
  input logic       dma_busy_i,
  input logic       dma_err_i,
  input logic       core_clk_en_o,
  input logic       standby_o,
  input pwr_state_e state
);
  AST_RUN_HOLDS_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == PWR_RUN && !wfi_req_i) |=> (state == PWR_RUN)); // R2

  AST_DRAIN_WAITS_MEM: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == PWR_DRAIN && mem_busy_i && !dma_err_i) |=> (state == PWR_DRAIN && core_clk_en_o)); // R3

  AST_DRAIN_WAITS_DMA: assert property (@(posedge clk_i) disable iff (!rst_n)
    (state == PWR_DRAIN && dma_busy_i && !dma_err_i) |=> (state == PWR_DRAIN && core_clk_en_o)); // R4

  AST_DMA_ERR_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((state == PWR_DRAIN || state == PWR_GATE) && dma_err_i) |=> (core_clk_en_o && !standby_o)); // R5

  AST_GATE_NEEDS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(core_clk_en_o) |-> $past(!mem_busy_i && !dma_busy_i && !dma_err_i)); // R6

  AST_CLK_OFF_BEFORE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(standby_o) |-> $past(!core_clk_en_o)); // R6

  AST_FLAG_CLK_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(standby_o && core_clk_en_o)); // R6

  AST_WAKE_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(standby_o) |-> core_clk_en_o); // R7
endmodule

bind wfi_standby_ctrl wfi_standby_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_n         (rst_n),
  .wfi_req_i     (wfi_req_i),
  .mem_busy_i    (mem_busy_i),
  .dma_busy_i    (dma_busy_i),
  .dma_err_i     (dma_err_i),
  .core_clk_en_o (core_clk_en_o),
  .standby_o     (standby_o),
  .state         (state_q)
);

// File: tb/wfi_standby_ctrl_tb_top.sv
module wfi_standby_ctrl_tb_top;
  localparam int NUM_IRQ = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wfi_req = 1'b0, mem_busy = 1'b0, dma_busy = 1'b0, dma_err = 1'b0;
  logic [NUM_IRQ-1:0] irq = '0;
  logic               dbg_req = 1'b0, dbg_en = 1'b0;
  logic               core_clk_en, dbg_clk_en, standby;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  wfi_standby_ctrl #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(2)) dut_i (
    .clk_i (clk), .rst_n (rst_n), .wfi_req_i (wfi_req), .mem_busy_i (mem_busy),
    .dma_busy_i (dma_busy), .dma_err_i (dma_err), .irq_i (irq), .dbg_req_i (dbg_req),
    .dbg_en_i (dbg_en), .core_clk_en_o (core_clk_en), .dbg_clk_en_o (dbg_clk_en),
    .standby_o (standby)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic expect_state(string req, logic clk_en_exp, logic stby_exp);
    check(req, "core_clk_en", core_clk_en, clk_en_exp);
    check(req, "standby", standby, stby_exp);
    check(req, "dbg_clk_en", dbg_clk_en, 1'b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1 expect_state("R1", 1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_state("R1", 1'b1, 1'b0);
  endtask

  // Pulse the request with both busy flags low; reach standby after three edges.
  task automatic enter_standby(string req);
    @(negedge clk); wfi_req = 1'b1;
    @(negedge clk); wfi_req = 1'b0;
    expect_state(req, 1'b1, 1'b0);
    @(negedge clk);
    expect_state(req, 1'b0, 1'b0);
    @(negedge clk);
    expect_state(req, 1'b0, 1'b1);
  endtask

  task automatic t_idle_run();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      expect_state("R2", 1'b1, 1'b0);
    end
  endtask

  task automatic t_mem_drain();
    mem_busy = 1'b1;
    @(negedge clk); wfi_req = 1'b1;
    @(negedge clk); wfi_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      expect_state("R3", 1'b1, 1'b0);
    end
    mem_busy = 1'b0;
    @(negedge clk);
    expect_state("R3", 1'b0, 1'b0);
    @(negedge clk);
    expect_state("R3", 1'b0, 1'b1);
    irq[0] = 1'b1;
    repeat (3) @(negedge clk);
    irq = '0;
    expect_state("R3", 1'b1, 1'b0);
  endtask

  task automatic t_dma_drain();
    dma_busy = 1'b1;
    @(negedge clk); wfi_req = 1'b1;
    @(negedge clk); wfi_req = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      expect_state("R4", 1'b1, 1'b0);
    end
    dma_busy = 1'b0;
    @(negedge clk);
    expect_state("R4", 1'b0, 1'b0);
    @(negedge clk);
    expect_state("R4", 1'b0, 1'b1);
    irq[3] = 1'b1;
    repeat (3) @(negedge clk);
    irq = '0;
    expect_state("R4", 1'b1, 1'b0);
  endtask

  task automatic t_dma_err_drain();
    dma_busy = 1'b1;
    @(negedge clk); wfi_req = 1'b1;
    @(negedge clk); wfi_req = 1'b0;
    dma_err = 1'b1;
    @(negedge clk); dma_err = 1'b0; dma_busy = 1'b0;
    expect_state("R5", 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      expect_state("R5", 1'b1, 1'b0);
    end
  endtask

  task automatic t_dma_err_gate();
    @(negedge clk); wfi_req = 1'b1;
    @(negedge clk); wfi_req = 1'b0;
    @(negedge clk);
    expect_state("R5", 1'b0, 1'b0);
    dma_err = 1'b1;
    @(negedge clk); dma_err = 1'b0;
    expect_state("R5", 1'b1, 1'b0);
    @(negedge clk);
    expect_state("R5", 1'b1, 1'b0);
  endtask

  task automatic t_irq_wake(int line);
    enter_standby("R6");
    irq[line] = 1'b1;
    @(negedge clk);
    expect_state("R7", 1'b0, 1'b1);
    @(negedge clk);
    expect_state("R7", 1'b0, 1'b1);
    @(negedge clk);
    expect_state("R7", 1'b1, 1'b0);
    irq = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_dbg_wake();
    dbg_en = 1'b0;
    enter_standby("R8");
    dbg_req = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      expect_state("R8", 1'b0, 1'b1);
    end
    dbg_en = 1'b1;
    @(negedge clk);
    expect_state("R8", 1'b1, 1'b0);
    dbg_req = 1'b0;
    repeat (3) @(negedge clk);
    enter_standby("R8");
    dbg_req = 1'b1;
    repeat (2) @(negedge clk);
    expect_state("R8", 1'b0, 1'b1);
    @(negedge clk);
    expect_state("R8", 1'b1, 1'b0);
    dbg_req = 1'b0;
    dbg_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_standby_dbg_clk();
    enter_standby("R9");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9", "dbg_clk_en", dbg_clk_en, 1'b1);
    end
  endtask

  task automatic t_reset_in_standby();
    rst_n = 1'b0;
    #1 expect_state("R10", 1'b1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    expect_state("R10", 1'b1, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    do_reset();
    t_idle_run();
    t_mem_drain();
    t_dma_drain();
    t_dma_err_drain();
    t_dma_err_gate();
    t_irq_wake(0);
    t_irq_wake(NUM_IRQ-1);
    t_dbg_wake();
    t_standby_dbg_clk();
    t_reset_in_standby();
    t_idle_run();
    finish_run();
  end
endmodule